// File: doc/BRIEF.md
# LIN UART Status Flag Register

This block keeps the eight sticky status flags of a UART that can run on a LIN bus. The receiver, the transmitter, the logic that compares the sent and received bus levels, and the autobaud measurement logic each report a one-cycle event pulse. Each pulse sets its flag, and the flag stays set until the access tied to it clears it. Those accesses are a read of the status byte, a read of the receive data register, a write of the transmit data register, or the transmitter moving a byte into its shift register. The packed byte is driven out continuously so that the register file can return it on a read.

The autobaud complete flag only has meaning for a bus slave. While the UART acts as bus master, that flag reads 0, its stored copy is cleared and its set events are dropped. When the flag is set and the autobaud interrupt enable is on, the block asserts a receive interrupt line. An overflow of the baud counter during autobaud is reported on two flags at once: the overrun flag and the autobaud complete flag.

Top module: `lin_status_reg`

## Requirements
- R1: After a synchronous active-low reset the status byte is 0x06. Bit layout: bit 7 receive data available, bit 6 physical layer error, bit 5 overrun, bit 4 framing error, bit 3 break detected, bit 2 transmit data register empty, bit 1 transmitter empty, bit 0 autobaud complete.
- R2: An event pulse sets its flag in the status byte one cycle later, and the flag stays set until its clearing access.
- R3: A receive data read (`rxdata_rd`) clears bits 7, 6, 5, 4 and 3 at the next edge.
- R4: A status read (`status_rd`) clears bits 6, 3 and 0 at the next edge and leaves the other bits as they are.
- R5: An autobaud counter overflow pulse sets both bit 5 and bit 0.
- R6: While `master_mode` is 1, bit 0 reads 0, autobaud events do not set it, and its stored value is cleared. It stays 0 after a return to slave mode until a new autobaud event arrives.
- R7: `rx_irq` is 1 exactly when bit 0 of the status byte is 1 and `abd_irq_en` is 1.
- R8: A transmit data write clears bit 2. A shift register load pulse sets bit 2 and clears bit 1. A shift-done pulse sets bit 1.
- R9: A set event in the same cycle as that flag's clearing access wins, and the flag stays (or becomes) 1.
- R10: A write to the status register address (`status_wr`) has no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_mode | input | 1 | 1 = LIN master, 0 = LIN slave |
| abd_irq_en | input | 1 | Autobaud interrupt enable |
| rx_byte_evt | input | 1 | Receiver stored a new byte |
| rx_overrun_evt | input | 1 | Receive data overrun |
| rx_frame_evt | input | 1 | Missing stop bit |
| bus_mismatch_evt | input | 1 | Transmitted and received bus bits differ |
| break_evt | input | 1 | Break of qualifying length detected |
| tx_load_evt | input | 1 | Transmit data moved into the shift register |
| tx_done_evt | input | 1 | Shift register finished its character |
| abd_done_evt | input | 1 | Autobaud character measured |
| abd_ovf_evt | input | 1 | Baud counter overflowed during autobaud |
| status_rd | input | 1 | Read strobe of the status register |
| rxdata_rd | input | 1 | Read strobe of the receive data register |
| txdata_wr | input | 1 | Write strobe of the transmit data register |
| status_wr | input | 1 | Write strobe to the status register address |
| status | output | 8 | Packed status byte |
| rx_irq | output | 1 | Autobaud receive interrupt |

## Verification
The in-line assertions check on every cycle the local rules: flags stay sticky, clears take effect one edge after their strobe, a set wins over a same-cycle clear, the autobaud overflow reports on both flags, bit 0 is silent in master mode, and a status write changes nothing. Only the bench can show that these rules hold together. It runs a reference model over long random mixes of events, strobes and mode changes, and it also checks the ordered scenarios: an autobaud flag cleared by entering master mode that stays clear after the return to slave mode, and the transmit empty flags following a write, load, done sequence.

// File: rtl/lin_status_pkg.sv
// Package: shared constants and bundles for the LIN UART status register.
// Assumes an 8-bit status byte; bit positions are fixed because the
// register file and software decode them.
package lin_status_pkg;

    localparam int FLAG_W   = 8;
    localparam int BIT_RDA  = 7;  // receive data available
    localparam int BIT_PLE  = 6;  // physical layer error
    localparam int BIT_OVR  = 5;  // overrun / autobaud overflow
    localparam int BIT_FRM  = 4;  // framing error
    localparam int BIT_BRK  = 3;  // break detected
    localparam int BIT_TDRE = 2;  // transmit data register empty
    localparam int BIT_TXE  = 1;  // transmitter empty
    localparam int BIT_ABD  = 0;  // autobaud complete

    localparam logic [FLAG_W-1:0] STATUS_RST = FLAG_W'(8'h06);

    // Event pulses from the datapath, one cycle each
    typedef struct packed {
        logic rx_byte;
        logic rx_overrun;
        logic rx_frame;
        logic bus_mismatch;
        logic brk;
        logic tx_load;
        logic tx_done;
        logic abd_done;
        logic abd_ovf;
    } lin_evt_t;

    // Register access strobes that carry clear side effects
    typedef struct packed {
        logic status_rd;
        logic rxdata_rd;
        logic txdata_wr;
    } lin_acc_t;

endpackage

// File: rtl/lin_flag_cell.sv
// Module: one sticky status flag.
// Assumes set and clear are single-cycle strobes; set has priority so an
// event coinciding with its clearing access is never lost.
module lin_flag_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    // Sticky storage: reset, then set over clear over hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= RST_VAL;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

endmodule

// File: rtl/lin_status_events.sv
// Module: maps event pulses and access strobes onto per-flag set and clear
// vectors. Purely combinational; assumes strobes are one cycle wide.
module lin_status_events
    import lin_status_pkg::*;
(
    input  lin_evt_t          evt_i,
    input  lin_acc_t          acc_i,
    input  logic              master_i,
    output logic [FLAG_W-1:0] set_o,
    output logic [FLAG_W-1:0] clr_o
);

    // Set sources: each flag's event, overflow feeding two flags
    always_comb begin
        set_o           = '0;
        set_o[BIT_RDA]  = evt_i.rx_byte;
        set_o[BIT_PLE]  = evt_i.bus_mismatch;
        set_o[BIT_OVR]  = evt_i.rx_overrun | evt_i.abd_ovf;
        set_o[BIT_FRM]  = evt_i.rx_frame;
        set_o[BIT_BRK]  = evt_i.brk;
        set_o[BIT_TDRE] = evt_i.tx_load;
        set_o[BIT_TXE]  = evt_i.tx_done;
        set_o[BIT_ABD]  = (evt_i.abd_done | evt_i.abd_ovf) & ~master_i;
    end

    // Clear sources: access side effects, shift load and master mode
    always_comb begin
        clr_o           = '0;
        clr_o[BIT_RDA]  = acc_i.rxdata_rd;
        clr_o[BIT_PLE]  = acc_i.rxdata_rd | acc_i.status_rd;
        clr_o[BIT_OVR]  = acc_i.rxdata_rd;
        clr_o[BIT_FRM]  = acc_i.rxdata_rd;
        clr_o[BIT_BRK]  = acc_i.rxdata_rd | acc_i.status_rd;
        clr_o[BIT_TDRE] = acc_i.txdata_wr;
        clr_o[BIT_TXE]  = evt_i.tx_load;
        clr_o[BIT_ABD]  = acc_i.status_rd | master_i;
    end

endmodule

// File: rtl/lin_status_reg.sv
// Module: LIN UART status flag register (top).
// Holds eight sticky flags, masks the autobaud flag in master mode and
// raises the autobaud receive interrupt. Assumes all inputs are synchronous
// to clk and strobes last one cycle. The status register is read-only.
module lin_status_reg
    import lin_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              abd_irq_en,
    input  logic              rx_byte_evt,
    input  logic              rx_overrun_evt,
    input  logic              rx_frame_evt,
    input  logic              bus_mismatch_evt,
    input  logic              break_evt,
    input  logic              tx_load_evt,
    input  logic              tx_done_evt,
    input  logic              abd_done_evt,
    input  logic              abd_ovf_evt,
    input  logic              status_rd,
    input  logic              rxdata_rd,
    input  logic              txdata_wr,
    input  logic              status_wr,
    output logic [FLAG_W-1:0] status,
    output logic              rx_irq
);

    lin_evt_t          evt;
    lin_acc_t          acc;
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] clr_vec;
    logic [FLAG_W-1:0] flag_q;
    logic              any_evt;
    logic              any_acc;

    // Bundle the event pulses
    always_comb begin
        evt.rx_byte      = rx_byte_evt;
        evt.rx_overrun   = rx_overrun_evt;
        evt.rx_frame     = rx_frame_evt;
        evt.bus_mismatch = bus_mismatch_evt;
        evt.brk          = break_evt;
        evt.tx_load      = tx_load_evt;
        evt.tx_done      = tx_done_evt;
        evt.abd_done     = abd_done_evt;
        evt.abd_ovf      = abd_ovf_evt;
    end

    // Bundle the access strobes that have side effects
    always_comb begin
        acc.status_rd = status_rd;
        acc.rxdata_rd = rxdata_rd;
        acc.txdata_wr = txdata_wr;
    end

    lin_status_events u_events (
        .evt_i    (evt),
        .acc_i    (acc),
        .master_i (master_mode),
        .set_o    (set_vec),
        .clr_o    (clr_vec)
    );

    // One sticky cell per flag, reset value taken from the package
    for (genvar g = 0; g < FLAG_W; g++) begin : g_flag
        lin_flag_cell #(
            .RST_VAL (STATUS_RST[g])
        ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[g]),
            .clr_i  (clr_vec[g]),
            .flag_o (flag_q[g])
        );
    end

    // Output byte: autobaud bit forced low while bus master
    always_comb begin
        status          = flag_q;
        status[BIT_ABD] = flag_q[BIT_ABD] & ~master_mode;
    end

    // Autobaud receive interrupt level
    assign rx_irq = status[BIT_ABD] & abd_irq_en;

    // Quiet-bus qualifiers used by the assertions
    assign any_evt = |evt;
    assign any_acc = |acc;

    // ---------------- assertions ----------------
    AST_RESET_VALUE: assert property (@(posedge clk)
        !rst_n |=> status == STATUS_RST); // R1

    AST_RDA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        status[BIT_RDA] && !rxdata_rd |=> status[BIT_RDA]); // R2

    AST_RXREAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rxdata_rd && !rx_byte_evt && !rx_frame_evt |=> !status[BIT_RDA] && !status[BIT_FRM]); // R3

    AST_STATREAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd && !break_evt && !bus_mismatch_evt |=> !status[BIT_BRK] && !status[BIT_PLE]); // R4

    AST_STATREAD_KEEPS_RDA: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd && !rxdata_rd && status[BIT_RDA] |=> status[BIT_RDA]); // R4

    AST_ABD_OVF_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        abd_ovf_evt && !master_mode |=> status[BIT_OVR] && (status[BIT_ABD] || master_mode)); // R5

    AST_MASTER_ABD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        master_mode |-> !status[BIT_ABD] && !rx_irq); // R6

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> abd_irq_en && !master_mode); // R7

    AST_TDRE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        txdata_wr && !tx_load_evt |=> !status[BIT_TDRE]); // R8

    AST_TXE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_evt && !tx_done_evt |=> !status[BIT_TXE] && status[BIT_TDRE]); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_byte_evt && rxdata_rd |=> status[BIT_RDA]); // R9

    AST_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        status_wr && !any_evt && !any_acc |=> status[FLAG_W-1:1] == $past(status[FLAG_W-1:1])); // R10

endmodule

// File: tb/lin_status_reg_bench.sv
`timescale 1ns/1ps
module lin_status_reg_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master = 1'b0;
    logic        irq_en = 1'b0;
    logic [12:0] stim = '0;   // 0 rx_byte,1 ovr,2 frame,3 mismatch,4 brk,5 tx_load,
                              // 6 tx_done,7 abd_done,8 abd_ovf,9 status_rd,10 rxdata_rd,
                              // 11 txdata_wr,12 status_wr
    logic [7:0]  status;
    logic        rx_irq;
    logic [7:0]  exp_q;       // model of stored flags
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    lin_status_reg u_lin_status_reg (
        .clk              (clk),
        .rst_n            (rst_n),
        .master_mode      (master),
        .abd_irq_en       (irq_en),
        .rx_byte_evt      (stim[0]),
        .rx_overrun_evt   (stim[1]),
        .rx_frame_evt     (stim[2]),
        .bus_mismatch_evt (stim[3]),
        .break_evt        (stim[4]),
        .tx_load_evt      (stim[5]),
        .tx_done_evt      (stim[6]),
        .abd_done_evt     (stim[7]),
        .abd_ovf_evt      (stim[8]),
        .status_rd        (stim[9]),
        .rxdata_rd        (stim[10]),
        .txdata_wr        (stim[11]),
        .status_wr        (stim[12]),
        .status           (status),
        .rx_irq           (rx_irq)
    );

    // One flag update: set over clear over hold (R2, R9)
    function automatic logic upd(logic q, logic s, logic c);
        return s ? 1'b1 : (c ? 1'b0 : q);
    endfunction

    // Next stored flags from the requirements (R2-R6, R8, R10)
    function automatic logic [7:0] model_next(logic [7:0] q, logic [12:0] s, logic m);
        logic [7:0] n;
        n[7] = upd(q[7], s[0], s[10]);
        n[6] = upd(q[6], s[3], s[10] | s[9]);
        n[5] = upd(q[5], s[1] | s[8], s[10]);
        n[4] = upd(q[4], s[2], s[10]);
        n[3] = upd(q[3], s[4], s[10] | s[9]);
        n[2] = upd(q[2], s[5], s[11]);
        n[1] = upd(q[1], s[6], s[5]);
        n[0] = upd(q[0], (s[7] | s[8]) & ~m, s[9] | m);
        return n;
    endfunction

    function automatic logic [7:0] model_out(logic [7:0] q, logic m);
        return {q[7:1], q[0] & ~m};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, expv);
        end
    endtask

    // Drive one cycle of stimulus, advance the model, check both outputs
    task automatic step(logic [12:0] s, string tag);
        stim = s;
        @(posedge clk);
        exp_q = model_next(exp_q, s, master);
        #1;
        stim = '0;
        check(tag, status, model_out(exp_q, master));
        check({tag, " R7 irq"}, {7'd0, rx_irq},
              {7'd0, model_out(exp_q, master) & {7'd0, irq_en}} );
    endtask

    initial begin
        void'($urandom(32'h1F5A_0C3D));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        exp_q = 8'h06;
        check("R1 reset value", status, 8'h06);

        // R2: receive byte sets bit 7, holds over idle
        step(13'h0001, "R2 set");
        check("R2 literal", status, 8'h86);
        step(13'h0000, "R2 hold");
        // R3: receive data read clears receive-side flags
        step(13'h001E, "R3 setup");
        step(13'h0400, "R3 rx read");
        check("R3 literal", status, 8'h06);
        // R4: status read clears only bits 6,3,0
        step(13'h0099, "R4 setup");
        check("R4 setup literal", status, 8'hCF);
        step(13'h0200, "R4 status read");
        check("R4 literal", status, 8'h86);
        step(13'h0400, "R4 cleanup");
        // R5 and R7: overflow sets bits 5 and 0, interrupt follows enable
        irq_en = 1'b1;
        step(13'h0100, "R5 overflow");
        check("R5 literal", status, 8'h27);
        check("R7 irq on", {7'd0, rx_irq}, 8'h01);
        irq_en = 1'b0;
        #1 check("R7 irq off", {7'd0, rx_irq}, 8'h00);
        irq_en = 1'b1;
        // R6: master clears and blocks autobaud flag
        master = 1'b1;
        step(13'h0080, "R6 master");
        check("R6 literal", status, 8'h26);
        master = 1'b0;
        step(13'h0000, "R6 back to slave");
        check("R6 stays clear", status, 8'h26);
        step(13'h0400, "R6 cleanup");
        // R8: transmit write, load, done sequence
        step(13'h0800, "R8 write");
        check("R8 write literal", status, 8'h02);
        step(13'h0020, "R8 load");
        check("R8 load literal", status, 8'h04);
        step(13'h0040, "R8 done");
        check("R8 done literal", status, 8'h06);
        // R9: set wins over same-cycle clear
        step(13'h0401, "R9 rx byte vs read");
        check("R9 literal", status, 8'h86);
        step(13'h0820, "R9 load vs write");
        // R10: write to status address changes nothing
        step(13'h1000, "R10 status write");
        check("R10 literal", status, 8'h84);

        // Random mix of events, strobes and mode changes
        for (int i = 0; i < 4000; i++) begin
            logic [12:0] s;
            s = '0;
            for (int b = 0; b < 13; b++)
                s[b] = ($urandom % 5) == 0;
            if (($urandom % 16) == 0) master = ~master;
            if (($urandom % 8) == 0) irq_en = ~irq_en;
            step(s, "R2 random");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule